// File: doc/BRIEF.md
# Free-Running Core Timer with Periodic Tick Flags

This block is a free-running timebase for a small controller. A binary divider chain advances on every clock. Its low eight bits form the core counter, which software can read. Taps further up the chain supply a periodic tick at one of four software-selectable rates. Each counter wrap and each tick sets a sticky event flag. Each flag has its own interrupt enable, and the two enabled sources are ORed onto a single interrupt request line.

Software reaches the block through a byte-wide register bus with a one-bit address, a write strobe, write data and combinational read data. Address 0 is the control/status byte and address 1 is the counter, which is read-only. The tick is also brought out as a single-cycle pulse so that a watchdog can count it. The clock prescaler ahead of the counter and interrupt vectoring belong to the surrounding logic and are not part of this block.

Top module: `core_timer`

## Requirements
- R1: After reset the status byte (address 0) reads 0x03, the counter (address 1) reads 0x00, and `irq` and `rti_tick` are low.
- R2: The counter advances by one on every clock and wraps from 0xFF to 0x00. A write to address 1 has no effect on the counter or on the status byte.
- R3: The overflow flag (status bit 7) becomes 1 on the clock edge at which the counter goes from 0xFF to 0x00.
- R4: The rate field (status bits 1:0, value r) selects a tick with a period of 2^(TAP_LO+r) clocks. Ticks fall on the edges where the number of clocks since reset, modulo 2^(TAP_LO+r), equals 2^(TAP_LO+r-1). The tick flag (status bit 6) becomes 1 on that edge.
- R5: `rti_tick` is high for exactly the one cycle that follows each tick edge.
- R6: Writing 0 to a flag bit at address 0 clears that flag. Writing 1 to a flag bit leaves the flag unchanged, so software cannot set a flag.
- R7: If a flag-setting event and a clearing write occur on the same edge, the flag ends up set.
- R8: A write to address 0 loads the overflow enable (bit 5), the tick enable (bit 4) and the rate (bits 1:0). Bits 3 and 2 always read 0.
- R9: `irq` is high while the overflow flag and its enable are both 1, or while the tick flag and its enable are both 1. Clearing an enable drops that source's request even though its flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register select: 0 status byte, 1 counter |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Combined interrupt request |
| rti_tick | output | 1 | One-cycle pulse per periodic tick |

## Verification
The bench drives clearing writes onto the exact edge where the counter wraps and onto the edge where the tick fires. A design that let the clear win there would lose an event, and the bench would see 0x00 where it expects 0x80 or 0xC0. It measures the phase of the first tick after each rate change. An off-by-one tap index would double or halve the period and put the tick at the wrong cycle count. It also writes ones into the flag bits, writes zeros into the enables while the flags stay set, and writes to the counter address. These catch designs that let software set flags, that keep requesting after an enable is cleared, or that decode the read-only counter as writable.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int RATE_W = 2;
    localparam int NTAP   = 1 << RATE_W;
    localparam int DATA_W = 8;

    localparam int BIT_OVF_FLAG = 7;
    localparam int BIT_RTI_FLAG = 6;

    localparam logic ADDR_CSR = 1'b0;
    localparam logic ADDR_CNT = 1'b1;

    typedef struct packed {
        logic              ovf_flag;
        logic              rti_flag;
        logic              ovf_en;
        logic              rti_en;
        logic [1:0]        zero;
        logic [RATE_W-1:0] rate;
    } csr_t;

    localparam csr_t CSR_RESET = '{ovf_flag: 1'b0, rti_flag: 1'b0,
                                   ovf_en: 1'b0, rti_en: 1'b0,
                                   zero: 2'b00, rate: {RATE_W{1'b1}}};

endpackage

// File: rtl/ct_divider.sv
module ct_divider
    import ct_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TAP_LO = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap_evt,
    output logic              tick_evt,
    output logic              rti_tick
);

    localparam int CH_W = TAP_LO + NTAP - 1;

    typedef struct packed {
        logic [CH_W-1:0] chain;
        logic            tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [NTAP-1:0] rise;

    // rising edge of each tap bit is about to occur at the coming edge
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        localparam int IDX = TAP_LO - 1 + k;
        assign rise[k] = (&st_q.chain[IDX-1:0]) & ~st_q.chain[IDX];
    end

    always_comb begin
        st_d       = st_q;
        st_d.chain = st_q.chain + 1'b1;
        st_d.tick  = rise[rate];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.chain[CNT_W-1:0];
    assign wrap_evt = &st_q.chain[CNT_W-1:0];
    assign tick_evt = rise[rate];
    assign rti_tick = st_q.tick;

endmodule

// File: rtl/ct_csr.sv
module ct_csr
    import ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap_evt,
    input  logic              tick_evt,
    output csr_t              csr
);

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d      = csr_q;
        csr_d.zero = 2'b00;
        if (wr_en) begin
            csr_d.ovf_flag = csr_q.ovf_flag & wdata[BIT_OVF_FLAG];
            csr_d.rti_flag = csr_q.rti_flag & wdata[BIT_RTI_FLAG];
            csr_d.ovf_en   = wdata[5];
            csr_d.rti_en   = wdata[4];
            csr_d.rate     = wdata[RATE_W-1:0];
        end
        // hardware events take priority over a same-edge clear
        if (wrap_evt) csr_d.ovf_flag = 1'b1;
        if (tick_evt) csr_d.rti_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= CSR_RESET;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign csr = csr_q;

endmodule

// File: rtl/ct_irq.sv
module ct_irq
    import ct_pkg::*;
(
    input  csr_t csr,
    output logic irq
);

    always_comb begin
        irq = (csr.ovf_flag & csr.ovf_en) | (csr.rti_flag & csr.rti_en);
    end

endmodule

// File: rtl/core_timer.sv
module core_timer
    import ct_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TAP_LO = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       rti_tick
);

    logic [CNT_W-1:0] cnt_w;
    logic             wrap_w;
    logic             tick_w;
    csr_t             csr_w;
    logic             csr_wr;

    assign csr_wr = we & (addr == ADDR_CSR);

    ct_divider #(.CNT_W(CNT_W), .TAP_LO(TAP_LO)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (csr_w.rate),
        .cnt      (cnt_w),
        .wrap_evt (wrap_w),
        .tick_evt (tick_w),
        .rti_tick (rti_tick)
    );

    ct_csr i_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr),
        .wdata    (wdata),
        .wrap_evt (wrap_w),
        .tick_evt (tick_w),
        .csr      (csr_w)
    );

    ct_irq i_irq (
        .csr (csr_w),
        .irq (irq)
    );

    always_comb begin
        if (addr == ADDR_CNT) begin
            rdata = DATA_W'(cnt_w);
        end else begin
            rdata = csr_w;
        end
    end

endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr,
    input logic             we,
    input logic [1:0]       wflags,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       csr,
    input logic             irq,
    input logic             rti_tick
);

    logic ctof, rtif, ctofe, rtie;
    assign ctof  = csr[7];
    assign rtif  = csr[6];
    assign ctofe = csr[5];
    assign rtie  = csr[4];

    p_cnt_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + 1'b1);

    p_ovf_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) |=> ctof);

    p_tick_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |-> rtif);

    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |=> !rti_tick);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctof && !(we && !addr && !wflags[1])) |=> ctof);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctof && we && !addr && !wflags[1] && !(&cnt)) |=> !ctof);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt) && we && !addr && !wflags[1]) |=> ctof);

    p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csr[3:2] == 2'b00);

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctofe && !rtie) |-> !irq);

    p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctof && ctofe) || (rtif && rtie)) |-> irq);

endmodule

bind core_timer ct_checker #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .we       (we),
    .wflags   (wdata[7:6]),
    .cnt      (cnt_w),
    .csr      (csr_w),
    .irq      (irq),
    .rti_tick (rti_tick)
);

// File: tb/test_core_timer.sv
`timescale 1ns/100ps
module test_core_timer;

    localparam int TAP = 9;

    typedef struct packed {
        logic [15:0] gap;
        logic [7:0]  exp_cnt;
        logic [7:0]  exp_csr;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'd1,   8'h01, 8'h03},
        '{16'd5,   8'h06, 8'h03},
        '{16'd100, 8'h6A, 8'h03},
        '{16'd149, 8'hFF, 8'h03},
        '{16'd1,   8'h00, 8'h83},
        '{16'd10,  8'h0A, 8'h83}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       rti_tick;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    core_timer #(.CNT_W(8), .TAP_LO(TAP)) i_core_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rti_tick(rti_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 1'b0;
    endtask

    task automatic wait_tick(output bit seen);
        seen = 0;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (rti_tick) begin seen = 1; break; end
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(1'b0, v); chk("R1 csr", v, 8'h03);
        rd(1'b1, v); chk("R1 cnt", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 tick", rti_tick, 0);
        addr = 1'b0;
        rst_n = 1'b1;

        // R2/R3 table walk
        for (int i = 0; i < NVEC; i++) begin
            repeat (VECS[i].gap) @(posedge clk);
            @(negedge clk);
            rd(1'b1, v); chk("R2 counter", v, VECS[i].exp_cnt);
            rd(1'b0, v); chk("R3 csr", v, VECS[i].exp_csr);
        end

        // R6/R8/R9: ones into flags keep them, enables load, pad reads 0
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk("R8 write enables", v, 8'hB3);
        chk("R9 irq from overflow", irq, 1);
        wr(1'b0, 8'h33);
        rd(1'b0, v); chk("R6 clear overflow", v, 8'h33);
        chk("R9 irq after clear", irq, 0);

        // R4/R5 rate 0, tick enabled
        wr(1'b0, 8'h10);
        wait_tick(seen);
        chk("R5 tick seen", seen, 1);
        chk("R4 tick phase rate0", ncyc % 512, 256);
        rd(1'b0, v); chk("R4 tick flag", v[6], 1);
        chk("R9 irq from tick", irq, 1);
        @(negedge clk);
        chk("R5 tick single cycle", rti_tick, 0);
        wr(1'b0, 8'hC0);
        rd(1'b0, v); chk("R9 flag kept", v[6], 1);
        chk("R9 enable removes irq", irq, 0);

        // R4 other rates
        for (int r = 1; r < 4; r++) begin
            wr(1'b0, 8'(r));
            wait_tick(seen);
            chk("R4 tick seen", seen, 1);
            chk("R4 tick phase", ncyc % (1 << (TAP + r)), 1 << (TAP + r - 1));
        end

        // R7 clear on the wrap edge (no tick there)
        wr(1'b0, 8'h00);
        while (ncyc % 512 != 511) @(negedge clk);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R7 overflow set wins", v, 8'h80);
        // R7 clear on an edge with both wrap and tick
        while (ncyc % 512 != 255) @(negedge clk);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R7 both set win", v, 8'hC0);

        // R2 counter address is read-only
        wr(1'b1, 8'h55);
        rd(1'b1, v); chk("R2 counter write ignored", v, ncyc % 256);
        rd(1'b0, v); chk("R2 csr untouched", v, 8'hC0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule